// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Codec

This block protects one memory word with an extended Hamming code. The encoder half takes a data word and forms a code word. The check bits sit at the power-of-two positions. The data bits fill the gaps, and one whole-word parity bit closes the word. The decoder half takes a word read back from storage and recomputes the check groups. The recomputed check bits form a syndrome, and the syndrome is the 1-based position of a single flipped bit.

The syndrome and the whole-word parity sort each read into one of four outcomes:
- clean;
- a single error, which the decoder repairs;
- a double error, which it reports and does not repair;
- a flip of the whole-word parity bit alone.

One parameter sets the data width, and the number of check bits follows from it. Four data bits give an 8-bit code and 64 data bits give a 72-bit code. A second parameter adds one register stage after the decoder. The encoder is always combinational.

Top module: `secded_codec`

## Requirements
- R1: Code positions are numbered from 1. Position k is held at code bit index CODE_W-k, so position 1 is the MSB. Check bits take positions 1, 2, 4, 8, and so on. Data bits fill the other positions up to HAM_W, with the data MSB first. The whole-word parity bit is code bit 0. For 4-bit data the layout from MSB down is c1 c2 d3 c4 d2 d1 d0 P.
- R2: Check bit at position 2^i gives even parity over every position 1..HAM_W whose index has bit i set.
- R3: The whole-word parity bit makes the full CODE_W-bit code word even parity.
- R4: A word read back unchanged gives syndrome 0 and all three flags low, and the data output equals the encoded data.
- R5: A single flip at position k (1..HAM_W) gives syndrome k and raises the single flag, and the data output equals the original data. A flip at a check-bit position leaves the data unchanged and still raises the single flag.
- R6: A flip of code bit 0 alone gives syndrome 0 and raises the parity flag only, and the data output is unchanged.
- R7: Two flips raise the double flag and leave the single flag low. The data output is then the data field of the received word, passed through without correction.
- R8: At most one of the single, double and parity flags is high at any time.
- R9: The check-bit count P is the smallest p with 2^p >= p+DATA_W+1. This gives a 3-bit syndrome for 4-bit data (8-bit code) and a 7-bit syndrome for 64-bit data (72-bit code).
- R10: With OUT_REG=1 every decoder output appears one clock after its input and resets to zero. With OUT_REG=0 the decoder outputs follow the input in the same cycle, and the encoder is always combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| enc_data_i | input | DATA_W | Data word to encode |
| enc_code_o | output | CODE_W | Encoded word |
| dec_code_i | input | CODE_W | Stored word to check |
| dec_data_o | output | DATA_W | Corrected (or passed-through) data |
| dec_syndrome_o | output | P | Recomputed check bits (error position) |
| dec_single_o | output | 1 | Single error corrected |
| dec_double_o | output | 1 | Uncorrectable double error |
| dec_parity_o | output | 1 | Only the whole-word parity bit is wrong |

## Verification
The encoder result is due in the same cycle, so the bench samples it one time step after it drives the data. In the registered 4-bit instance the decoder results are due one clock edge after the input. The bench therefore drives a word on a falling edge and checks on the next falling edge. It also confirms that the outputs still hold the old value just after the drive. In the combinational 64-bit instance the decoder results are sampled one time step after the drive, away from any rising edge.

// File: rtl/secded_pkg.sv
package secded_pkg;
  // smallest p with 2^p >= p + d + 1
  function automatic int check_count(input int d);
    int p;
    p = 1;
    while ((1 << p) < (p + d + 1)) p++;
    return p;
  endfunction

  function automatic bit is_pow2(input int k);
    return (k > 0) && ((k & (k - 1)) == 0);
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int P_W    = check_count(DATA_W),
  localparam int HAM_W  = DATA_W + P_W,
  localparam int CODE_W = HAM_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);
  logic [HAM_W:1] hv;

  always_comb begin
    int j;
    logic s;
    hv = '0;
    j  = DATA_W - 1;
    for (int k = 1; k <= HAM_W; k++) begin
      if (!is_pow2(k)) begin
        hv[k] = data_i[j];
        j--;
      end
    end
    for (int i = 0; i < P_W; i++) begin
      s = 1'b0;
      for (int k = 1; k <= HAM_W; k++)
        if (((k >> i) & 1) == 1) s ^= hv[k];
      hv[1 << i] = s;
    end
  end

  always_comb begin
    code_o = '0;
    for (int k = 1; k <= HAM_W; k++) code_o[CODE_W-k] = hv[k];
    code_o[0] = ^hv;
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int P_W    = check_count(DATA_W),
  localparam int HAM_W  = DATA_W + P_W,
  localparam int CODE_W = HAM_W + 1
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] raw_data_o,
  output logic [P_W-1:0]    syndrome_o,
  output logic              single_o,
  output logic              double_o,
  output logic              parity_o
);
  function automatic logic [DATA_W-1:0] pull_data(input logic [HAM_W:1] h);
    logic [DATA_W-1:0] d;
    int j;
    d = '0;
    j = DATA_W - 1;
    for (int k = 1; k <= HAM_W; k++) begin
      if (!is_pow2(k)) begin
        d[j] = h[k];
        j--;
      end
    end
    return d;
  endfunction

  logic [HAM_W:1] rx, fixed;
  logic           whole_par;
  logic           syn_nz;

  always_comb begin
    for (int k = 1; k <= HAM_W; k++) rx[k] = code_i[CODE_W-k];
  end

  always_comb begin
    logic s;
    for (int i = 0; i < P_W; i++) begin
      s = 1'b0;
      for (int k = 1; k <= HAM_W; k++)
        if (((k >> i) & 1) == 1) s ^= rx[k];
      syndrome_o[i] = s;
    end
  end

  assign whole_par = ^code_i;
  assign syn_nz    = |syndrome_o;
  assign single_o  = syn_nz && whole_par && (int'(syndrome_o) <= HAM_W);
  assign double_o  = syn_nz && !single_o;
  assign parity_o  = !syn_nz && whole_par;

  always_comb begin
    fixed = rx;
    for (int k = 1; k <= HAM_W; k++)
      if (single_o && (int'(syndrome_o) == k)) fixed[k] = ~rx[k];
  end

  assign data_o     = pull_data(fixed);
  assign raw_data_o = pull_data(rx);
endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter bit OUT_REG = 1'b0,
  localparam int P_W    = check_count(DATA_W),
  localparam int HAM_W  = DATA_W + P_W,
  localparam int CODE_W = HAM_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic [CODE_W-1:0] enc_code_o,
  input  logic [CODE_W-1:0] dec_code_i,
  output logic [DATA_W-1:0] dec_data_o,
  output logic [P_W-1:0]    dec_syndrome_o,
  output logic              dec_single_o,
  output logic              dec_double_o,
  output logic              dec_parity_o
);
  logic [DATA_W-1:0] c_data, c_raw;
  logic [P_W-1:0]    c_syn;
  logic              c_single, c_double, c_parity;

  secded_enc #(.DATA_W(DATA_W)) u_enc (
    .data_i (enc_data_i),
    .code_o (enc_code_o)
  );

  secded_dec #(.DATA_W(DATA_W)) u_dec (
    .code_i     (dec_code_i),
    .data_o     (c_data),
    .raw_data_o (c_raw),
    .syndrome_o (c_syn),
    .single_o   (c_single),
    .double_o   (c_double),
    .parity_o   (c_parity)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dec_data_o     <= '0;
          dec_syndrome_o <= '0;
          dec_single_o   <= 1'b0;
          dec_double_o   <= 1'b0;
          dec_parity_o   <= 1'b0;
        end else begin
          dec_data_o     <= c_data;
          dec_syndrome_o <= c_syn;
          dec_single_o   <= c_single;
          dec_double_o   <= c_double;
          dec_parity_o   <= c_parity;
        end
      end
      // R10: registered outputs lag the decode logic by one clock
      a_r10_reg_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dec_syndrome_o == $past(c_syn)) && (dec_data_o == $past(c_data)));
    end else begin : g_comb
      assign dec_data_o     = c_data;
      assign dec_syndrome_o = c_syn;
      assign dec_single_o   = c_single;
      assign dec_double_o   = c_double;
      assign dec_parity_o   = c_parity;
    end
  endgenerate

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({c_single, c_double, c_parity}));
  a_r4_loopback_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_code_i == enc_code_o) |-> (c_syn == '0) && !c_single && !c_double && !c_parity
                                   && (c_data == enc_data_i));
  a_r7_double_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    c_double |-> (c_data == c_raw));
  a_r6_parity_only: assert property (@(posedge clk) disable iff (!rst_n)
    c_parity |-> (c_syn == '0) && (c_data == c_raw));
  a_r4_quiet_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !(c_single || c_double || c_parity) |-> (c_data == c_raw));
endmodule

// File: tb/tb_secded_codec.sv
module tb_secded_codec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // small registered instance
  logic [3:0] ed4;
  logic [7:0] ec4, dc4;
  logic [3:0] dd4;
  logic [2:0] ds4;
  logic s4, d4, p4;
  secded_codec #(.DATA_W(4), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .enc_data_i(ed4), .enc_code_o(ec4),
    .dec_code_i(dc4), .dec_data_o(dd4), .dec_syndrome_o(ds4),
    .dec_single_o(s4), .dec_double_o(d4), .dec_parity_o(p4));

  // wide combinational instance
  logic [63:0] edw;
  logic [71:0] ecw, dcw;
  logic [63:0] ddw;
  logic [6:0]  dsw;
  logic sw, dw, pw;
  secded_codec #(.DATA_W(64), .OUT_REG(1'b0)) dut_w (
    .clk(clk), .rst_n(rst_n), .enc_data_i(edw), .enc_code_o(ecw),
    .dec_code_i(dcw), .dec_data_o(ddw), .dec_syndrome_o(dsw),
    .dec_single_o(sw), .dec_double_o(dw), .dec_parity_o(pw));

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_code4(input logic [3:0] d);
    logic c1, c2, c4;
    logic [6:0] h;
    c1 = d[3] ^ d[2] ^ d[0];
    c2 = d[3] ^ d[1] ^ d[0];
    c4 = d[2] ^ d[1] ^ d[0];
    h  = {c1, c2, d[3], c4, d[2], d[1], d[0]};
    return {h, ^h};
  endfunction

  function automatic logic [3:0] field4(input logic [7:0] c);
    return {c[5], c[3], c[2], c[1]};
  endfunction

  task automatic dec4(input logic [7:0] cw, input logic [3:0] xd, input logic [2:0] xs,
                      input bit xsg, input bit xdb, input bit xpa, input string req);
    @(negedge clk);
    dc4 = cw;
    @(negedge clk);
    chk(ds4 == xs, {req, " syndrome"}, 128'(ds4), 128'(xs));
    chk(dd4 == xd, {req, " data"}, 128'(dd4), 128'(xd));
    chk({s4, d4, p4} == {xsg, xdb, xpa}, {req, " flags"}, 128'({s4, d4, p4}),
        128'({xsg, xdb, xpa}));
  endtask

  task automatic decw(input logic [71:0] cw, input logic [63:0] xd, input logic [6:0] xs,
                      input bit xsg, input bit xdb, input bit xpa, input string req);
    @(negedge clk);
    dcw = cw;
    #1;
    chk(dsw == xs, {req, " wide syndrome"}, 128'(dsw), 128'(xs));
    chk(ddw == xd, {req, " wide data"}, 128'(ddw), 128'(xd));
    chk({sw, dw, pw} == {xsg, xdb, xpa}, {req, " wide flags"}, 128'({sw, dw, pw}),
        128'({xsg, xdb, xpa}));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  c8;
    logic [71:0] c72;
    logic [63:0] pat [5];
    ed4 = '0; dc4 = '0; edw = '0; dcw = '0;
    repeat (3) @(negedge clk);
    // R10: reset value of registered outputs
    chk({dd4, ds4, s4, d4, p4} == '0, "R10 reset outputs zero", 128'({dd4, ds4, s4, d4, p4}), 0);
    // R9: syndrome widths follow the check-bit count
    chk($bits(ds4) == 3 && $bits(ec4) == 8, "R9 4-bit widths", $bits(ds4), 3);
    chk($bits(dsw) == 7 && $bits(ecw) == 72, "R9 64-bit widths", $bits(dsw), 7);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 16; v++) begin
      ed4 = 4'(v);
      #1;
      c8 = ref_code4(4'(v));
      chk(ec4 == c8, "R1 R2 layout and check bits", 128'(ec4), 128'(c8));
      chk(^ec4 == 1'b0, "R3 whole word even", 128'(^ec4), 0);
      dec4(c8, 4'(v), 3'd0, 0, 0, 0, "R4 clean");
      for (int k = 1; k <= 7; k++)
        dec4(c8 ^ (8'h80 >> (k - 1)), 4'(v), 3'(k), 1, 0, 0, "R5 single flip");
      dec4(c8 ^ 8'h01, 4'(v), 3'd0, 0, 0, 1, "R6 parity bit flip");
      for (int a = 1; a <= 8; a++)
        for (int b = a + 1; b <= 8; b++) begin
          logic [7:0] cc;
          cc = c8 ^ (8'h80 >> (a - 1)) ^ (8'h80 >> (b - 1));
          dec4(cc, field4(cc), (b == 8) ? 3'(a) : 3'(a ^ b), 0, 1, 0, "R7 R8 double flip");
        end
    end

    // R10: registered output holds the old value right after a new drive
    @(negedge clk);
    dc4 = ref_code4(4'hA);
    @(negedge clk);
    dc4 = ref_code4(4'h5);
    #1;
    chk(dd4 == 4'hA, "R10 one-clock latency", 128'(dd4), 128'(4'hA));
    @(negedge clk);
    chk(dd4 == 4'h5, "R10 value after edge", 128'(dd4), 128'(4'h5));

    pat[0] = 64'h0;
    pat[1] = '1;
    pat[2] = 64'h0123_4567_89AB_CDEF;
    pat[3] = 64'h8000_0000_0000_0001;
    pat[4] = 64'hA5A5_5A5A_F00F_0FF0;
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      edw = pat[n];
      #1;
      c72 = ecw;
      chk(^c72 == 1'b0, "R3 wide even parity", 128'(^c72), 0);
      decw(c72, pat[n], 7'd0, 0, 0, 0, "R4 clean");
      for (int k = 1; k <= 71; k++)
        decw(c72 ^ ({1'b1, 71'd0} >> (k - 1)), pat[n], 7'(k), 1, 0, 0, "R5 single flip");
      decw(c72 ^ 72'd1, pat[n], 7'd0, 0, 0, 1, "R6 parity bit flip");
      decw(c72 ^ ({1'b1, 71'd0} >> 2) ^ ({1'b1, 71'd0} >> 69), pat[n] ^ 64'h8000_0000_0000_0002,
           7'(3 ^ 70), 0, 1, 0, "R7 wide double flip");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule